// File: doc/BRIEF.md
# Protection Region Permission Checker

This block checks accesses on a 32-bit address bus against two banks of base/limit protection regions. One bank serves a hypervisor regime and the other serves an OS/user regime. Each access names its address, its kind (read, write or instruction fetch), whether it is privileged, and which regime applies. The block searches every enabled region of the selected bank. One cycle later it reports:

- whether exactly one region matched, and that region's index;
- the read, write and execute permissions granted to the accessor;
- the memory attribute byte chosen by the region;
- whether the background region was used;
- whether the access faults.

A simple write port programs the regions. Each regime also has a control word and a 64-bit attribute register, written through the same port. Accesses that land in more than one region fault, whatever the region numbering. Accesses that land in no region also fault, unless the privileged background region is enabled for that regime. Execute rights are also withheld by two write-XOR-execute controls.

Top module: `prot_region_checker`

## Requirements
- R1: Region n of a bank spans from its base word with bits [5:0] cleared up to its limit word with bits [5:0] set, both ends inclusive. It can match only while bit 0 of its limit word is 1.
- R2: When exactly one enabled region of the selected bank contains the address, rsp_hit is 1 and rsp_region holds that region's index. When two or more contain it, rsp_hit is 0, all three permissions are 0 and rsp_fault is 1.
- R3: req_hyp=1 selects the hypervisor bank, control word and attribute register; req_hyp=0 selects the OS bank. The two sets are fully independent.
- R4: Base word bits [2:1] encode access rights. 0 gives privileged read/write, 1 gives read/write to all, 2 gives privileged read-only, and 3 gives read-only to all. Rights not given to the accessor read as 0.
- R5: Execute is granted on a single hit only when read or write is granted and base bit 0 is clear. It is also withheld when control bit 1 is set and write is granted. In the OS regime it is also withheld when control bit 2 is set and the rights field equals 1. Control bit 2 has no effect in the hypervisor regime.
- R6: rsp_attr is the byte at bit offset 8*k of the regime's attribute register, where k is limit bits [3:1] of the matched region. It is 0 when there is no single hit.
- R7: On a miss (no region matches), a privileged access whose regime has control bit 0 set uses the background region. It gets rsp_bgnd=1, all three permissions, rsp_region 0 and no fault. Any other miss faults with no permissions.
- R8: rsp_fault is 1 exactly when the requested kind is not granted. The kinds are req_type 0 read, 1 write and 2 fetch. req_type 3 always faults.
- R9: The response appears with rsp_valid one cycle after req_valid. A register write takes effect for requests from the next cycle on. cfg_kind 0 writes a base word, 1 a limit word, 2 the control word, 3 attribute bits [31:0] and 4 attribute bits [63:32].
- R10: Reset clears all region words, control words and attribute registers, so every access misses and faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_hyp | input | 1 | Write targets hypervisor (1) or OS (0) set |
| cfg_kind | input | 3 | Which register: 0 base, 1 limit, 2 control, 3 attr low, 4 attr high |
| cfg_idx | input | IW | Region index for base/limit writes |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_type | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_priv | input | 1 | Access is privileged |
| req_hyp | input | 1 | Access belongs to hypervisor regime |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | Exactly one region matched |
| rsp_region | output | IW | Matched region index |
| rsp_perm_r | output | 1 | Read granted |
| rsp_perm_w | output | 1 | Write granted |
| rsp_perm_x | output | 1 | Execute granted |
| rsp_attr | output | 8 | Memory attribute byte |
| rsp_bgnd | output | 1 | Background region used |
| rsp_fault | output | 1 | Access faults |

## Verification
The embedded properties check, on every response cycle:
- the response strobe timing;
- that write permission never comes without read, and execute never comes without read;
- that a granted read is never reported as a read fault;
- that a miss not covered by the background region always faults;
- that a background response never carries a hit or an attribute.

The region geometry is left to the bench's sweeps:
- the inclusive 64-byte-rounded edges;
- overlap faulting;
- bank separation;
- the rights encoding;
- both execute-never controls, including the unprivileged one being ignored for the hypervisor;
- the attribute byte selection.

These sweeps probe every region edge under all control-word combinations, for both regimes and both privilege levels. Only directed scenarios show reset clearing and the one-cycle delay between a register write and its use.

// File: rtl/prot_region_checker.sv
module prot_region_checker #(
  parameter int NREG = 16,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_hyp,
  input  logic [2:0]    cfg_kind,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  input  logic [1:0]    req_type,
  input  logic          req_priv,
  input  logic          req_hyp,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_region,
  output logic          rsp_perm_r,
  output logic          rsp_perm_w,
  output logic          rsp_perm_x,
  output logic [7:0]    rsp_attr,
  output logic          rsp_bgnd,
  output logic          rsp_fault
);

  logic [31:0] base_q  [2][NREG];
  logic [31:0] limit_q [2][NREG];
  logic [2:0]  ctrl_q  [2];
  logic [63:0] attr_q  [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        for (int n = 0; n < NREG; n++) begin
          base_q[h][n]  <= '0;
          limit_q[h][n] <= '0;
        end
        ctrl_q[h] <= '0;
        attr_q[h] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_kind)
        3'd0: base_q[cfg_hyp][cfg_idx]  <= cfg_wdata;
        3'd1: limit_q[cfg_hyp][cfg_idx] <= cfg_wdata;
        3'd2: ctrl_q[cfg_hyp]           <= cfg_wdata[2:0];
        3'd3: attr_q[cfg_hyp][31:0]     <= cfg_wdata;
        3'd4: attr_q[cfg_hyp][63:32]    <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = limit_q[req_hyp][g][0]
                    && (req_addr[31:6] >= base_q[req_hyp][g][31:6])
                    && (req_addr[31:6] <= limit_q[req_hyp][g][31:6]);
  end

  logic [IW-1:0] idx;
  always_comb begin
    idx = '0;
    for (int n = NREG - 1; n >= 0; n--)
      if (match[n]) idx = IW'(n);
  end

  logic       single, miss, bg, r, w, xn, pr, pw, px, flt;
  logic [1:0] ap;
  logic [2:0] ctl, aidx;

  assign single = (match != '0) && ((match & (match - 1'b1)) == '0);
  assign miss   = (match == '0);
  assign ctl    = ctrl_q[req_hyp];
  assign ap     = base_q[req_hyp][idx][2:1];
  assign aidx   = limit_q[req_hyp][idx][3:1];
  assign r      = single && (ap[0] || req_priv);
  assign w      = single && !ap[1] && (ap[0] || req_priv);
  assign xn     = base_q[req_hyp][idx][0] || (ctl[1] && w)
                  || (!req_hyp && ctl[2] && ap == 2'd1);
  assign bg     = miss && req_priv && ctl[0];
  assign pr     = r || bg;
  assign pw     = w || bg;
  assign px     = ((r || w) && !xn) || bg;

  always_comb begin
    case (req_type)
      2'd0:    flt = !pr;
      2'd1:    flt = !pw;
      2'd2:    flt = !px;
      default: flt = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_perm_r <= 1'b0;
      rsp_perm_w <= 1'b0;
      rsp_perm_x <= 1'b0;
      rsp_attr   <= '0;
      rsp_bgnd   <= 1'b0;
      rsp_fault  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= single;
        rsp_region <= single ? idx : '0;
        rsp_perm_r <= pr;
        rsp_perm_w <= pw;
        rsp_perm_x <= px;
        rsp_attr   <= single ? attr_q[req_hyp][aidx*8 +: 8] : 8'h00;
        rsp_bgnd   <= bg;
        rsp_fault  <= flt;
      end
    end
  end

  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm_w |-> rsp_perm_r);
  a_r5_exec_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm_x |-> rsp_perm_r);
  a_r8_read_granted_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm_r && $past(req_type) == 2'd0 |-> !rsp_fault);
  a_r7_uncovered_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit && !rsp_bgnd |-> rsp_fault && !rsp_perm_r);
  a_r7_bgnd_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_bgnd |-> !rsp_hit && rsp_attr == 8'h00 && !rsp_fault == ($past(req_type) != 2'd3));

endmodule

// File: tb/prot_region_checker_tb.sv
module prot_region_checker_tb_top;
  localparam int NREG = 16;
  localparam int IW = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_hyp = 0;
  logic [2:0] cfg_kind = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_priv = 0, req_hyp = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_type = 0;
  logic rsp_valid, rsp_hit, rsp_perm_r, rsp_perm_w, rsp_perm_x, rsp_bgnd, rsp_fault;
  logic [IW-1:0] rsp_region;
  logic [7:0] rsp_attr;

  int n_chk = 0, n_bad = 0;
  logic [31:0] sb [2][NREG];
  logic [31:0] sl [2][NREG];
  logic [2:0]  sc [2];
  logic [63:0] sa [2];

  always #2 clk = ~clk;

  prot_region_checker #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hyp(cfg_hyp),
    .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type),
    .req_priv(req_priv), .req_hyp(req_hyp), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_perm_r(rsp_perm_r),
    .rsp_perm_w(rsp_perm_w), .rsp_perm_x(rsp_perm_x), .rsp_attr(rsp_attr),
    .rsp_bgnd(rsp_bgnd), .rsp_fault(rsp_fault));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic h, input logic [2:0] k, input int i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_hyp = h; cfg_kind = k; cfg_idx = IW'(i); cfg_wdata = d;
    case (k)
      3'd0: sb[h][i] = d;
      3'd1: sl[h][i] = d;
      3'd2: sc[h] = d[2:0];
      3'd3: sa[h][31:0] = d;
      3'd4: sa[h][63:32] = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] t, input logic p, input logic h);
    logic [NREG-1:0] m;
    int cnt, hit_i;
    logic [1:0] ap;
    logic er, ew, ex, eb, ef, xn;
    logic [7:0] eattr;
    cnt = 0; hit_i = 0;
    for (int n = NREG - 1; n >= 0; n--) begin
      m[n] = sl[h][n][0] && (a[31:6] >= sb[h][n][31:6]) && (a[31:6] <= sl[h][n][31:6]);
      if (m[n]) begin cnt++; hit_i = n; end
    end
    ap = sb[h][hit_i][2:1];
    er = 0; ew = 0; ex = 0; eattr = 0;
    if (cnt == 1) begin
      case (ap)
        2'd0: begin er = p; ew = p; end
        2'd1: begin er = 1; ew = 1; end
        2'd2: er = p;
        default: er = 1;
      endcase
      xn = sb[h][hit_i][0] | (sc[h][1] & ew) | (!h & sc[h][2] & (ap == 2'd1));
      ex = (er | ew) & !xn;
      eattr = sa[h][sl[h][hit_i][3:1]*8 +: 8];
    end
    eb = (cnt == 0) && p && sc[h][0];
    if (eb) begin er = 1; ew = 1; ex = 1; end
    ef = (t == 0) ? !er : (t == 1) ? !ew : (t == 2) ? !ex : 1'b1;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_type = t; req_priv = p; req_hyp = h;
    @(negedge clk);
    req_valid = 0;
    chk("R9 rsp_valid", 32'(rsp_valid), 1);
    chk("R2 hit", 32'(rsp_hit), 32'(cnt == 1));
    chk("R2 region", 32'(rsp_region), (cnt == 1) ? hit_i : 0);
    chk("R4 read", 32'(rsp_perm_r), 32'(er));
    chk("R4 write", 32'(rsp_perm_w), 32'(ew));
    chk("R5 exec", 32'(rsp_perm_x), 32'(ex));
    chk("R6 attr", 32'(rsp_attr), 32'(eattr));
    chk("R7 bgnd", 32'(rsp_bgnd), 32'(eb));
    chk("R8 fault", 32'(rsp_fault), 32'(ef));
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] geo_b, geo_e;
    for (int h = 0; h < 2; h++) begin
      for (int n = 0; n < NREG; n++) begin sb[h][n] = 0; sl[h][n] = 0; end
      sc[h] = 0; sa[h] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 rsp_valid after reset", 32'(rsp_valid), 0);
    // R10: cleared state, every access misses and faults
    access(32'h0000_0000, 2'd0, 1'b1, 1'b0);
    access(32'h0000_1000, 2'd2, 1'b1, 1'b1);

    // R9: write and request in the same cycle see the old state
    @(negedge clk);
    cfg_we = 1; cfg_hyp = 0; cfg_kind = 3'd1; cfg_idx = IW'(9); cfg_wdata = 32'h8000_0001;
    req_valid = 1; req_addr = 32'h8000_0010; req_type = 0; req_priv = 1; req_hyp = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    sl[0][9] = 32'h8000_0001; sb[0][9] = 0;
    chk("R9 write not yet visible hit", 32'(rsp_hit), 0);
    chk("R9 write not yet visible fault", 32'(rsp_fault), 1);
    wr(0, 3'd0, 9, 32'h8000_0002);
    access(32'h8000_0010, 2'd0, 1'b0, 1'b0);

    // R1 R3 R4 R6: program both banks with distinct geometry
    wr(0, 3'd3, 0, 32'h4433_2211); wr(0, 3'd4, 0, 32'h8877_6655);
    wr(1, 3'd3, 0, 32'hC3B2_A190); wr(1, 3'd4, 0, 32'hF7E6_D5C4);
    for (int n = 0; n < 8; n++) begin
      wr(0, 3'd0, n, (32'h1000 * (n + 1)) | 32'h28 | (n % 8));
      wr(0, 3'd1, n, (32'h1000 * (n + 1) + 32'h7C0) | 32'h30 | ((n % 8) << 1) | (n != 6));
      wr(1, 3'd0, n, (32'h1000 * (n + 1) + 32'h800) | ((7 - n) & 7));
      wr(1, 3'd1, n, (32'h1000 * (n + 1) + 32'hBC0) | (((n + 3) % 8) << 1) | (n != 3));
    end
    wr(0, 3'd0, 8, 32'h1400 | 32'h2); wr(0, 3'd1, 8, 32'h14C0 | 32'h1);
    wr(1, 3'd0, 8, 32'h2900);         wr(1, 3'd1, 8, 32'h29C0 | 32'h5);

    for (int c = 0; c < 8; c++) begin
      wr(0, 3'd2, 0, 32'(c));
      wr(1, 3'd2, 0, 32'(c));
      for (int g = 0; g < 2; g++)
        for (int n = 0; n < 9; n++) begin
          geo_b = sb[g][n] & 32'hFFFF_FFC0;
          geo_e = sl[g][n] | 32'h3F;
          for (int pr = 0; pr < 4; pr++)
            for (int t = 0; t < 4; t++)
              for (int p = 0; p < 2; p++)
                for (int h = 0; h < 2; h++)
                  access((pr == 0) ? geo_b - 1 : (pr == 1) ? geo_b :
                         (pr == 2) ? geo_e : geo_e + 1,
                         2'(t), 1'(p), 1'(h));
        end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule